// File: doc/BRIEF.md
# Scan Reset Value Mapping Checker

This block compares two views of the same bank of scannable state bits once a scan-shift reset has placed every flop in a known value. One view is the reference model and the other is the implementation. Each bit position has two fixed properties. The first is the value it takes under scan reset. The second is a polarity flag that says whether the implementation stores the bit as is or inverted. From these two properties the block knows, for each bit, whether the two views should be equal or opposite after reset.

The comparison fires once, when the scan-shift enable input goes from high to low. At that moment the block registers a per-bit mismatch vector. It adds the number of mismatching bits to a saturating error counter. It also sets a sticky flag if any bit disagreed. A synchronous clear input zeroes the counter and the flag. Grouped registers with a multi-bit reset value need no special handling: each bit is checked against its own bit of the reset-value and polarity vectors.

Top module: `scanRvChecker`

## Requirements
- R1: After reset (`rstN` low), `mismatchVec`, `errCount` and `anyError` are all zero.
- R2: A capture happens only on the clock edge at which `scanEn` is sampled low after being sampled high on the previous edge. Changes to `refBits`/`implBits` while `scanEn` stays high, or stays low, leave all outputs unchanged.
- R3: For a bit with reset value 0 and direct polarity (flag 0), equal reference and implementation bits give mismatch 0, and differing bits give mismatch 1.
- R4: For a bit with reset value 0 and inverted polarity (flag 1), differing bits give mismatch 0, and equal bits give mismatch 1.
- R5: For a bit with reset value 1 and direct polarity, differing bits give mismatch 0, and equal bits give mismatch 1.
- R6: For a bit with reset value 1 and inverted polarity, equal bits give mismatch 0, and differing bits give mismatch 1.
- R7: Bit i of `mismatchVec` is judged using only bit i of `RESET_VAL` and bit i of `INVERT_MAP`, so a multi-bit value such as 4'b0101 is checked bit by bit.
- R8: On each capture, `errCount` grows by the number of 1 bits in the new mismatch vector.
- R9: `errCount` saturates at 2^CNT_W-1 and never wraps.
- R10: When `clrCnt` is high at a clock edge, `errCount` and `anyError` become 0 on that edge. This holds even if a capture happens on the same edge. `mismatchVec` still follows the capture and is otherwise untouched by `clrCnt`.
- R11: `anyError` is set by a capture with at least one mismatching bit. It then stays set until cleared, even through later captures that have no mismatch.
- R12: `mismatchVec` keeps its value between captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanEn | input | 1 | Scan-shift enable; its falling edge triggers the check |
| clrCnt | input | 1 | Synchronous clear of the counter and sticky flag |
| refBits | input | WIDTH | Reference view of the state bits |
| implBits | input | WIDTH | Implementation view of the state bits |
| mismatchVec | output | WIDTH | Per-bit mismatch result of the last capture |
| errCount | output | CNT_W | Saturating count of mismatching bits |
| anyError | output | 1 | Sticky flag: some capture had a mismatch |

## Verification
The assertions in the RTL check several properties on every cycle. The mismatch vector holds its value between captures. Captures never occur back to back, and each one follows a low `scanEn`. The counter never decreases except on clear, and it holds at saturation. The sticky flag survives until a clear, and a clear empties both the counter and the flag. Only the bench's scenarios can show the rest: the correct pass or fail decision for each of the four reset-value and polarity combinations, the exact amount added to the counter, the point where it saturates, and the priority of a clear over a capture on the same edge.

// File: rtl/scanrv_pkg.sv
package scanrv_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } rvStrobes_t;
endpackage

// File: rtl/scanrv_ctrl.sv
module scanrv_ctrl
  import scanrv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scanEn,
  input  logic       clrCnt,
  output rvStrobes_t strobes
);
  logic scanEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) scanEnQ <= 1'b0;
    else       scanEnQ <= scanEn;
  end

  always_comb begin
    strobes.capture = scanEnQ & ~scanEn;
    strobes.clear   = clrCnt;
  end

  // R2: a falling edge cannot repeat on consecutive cycles
  assert_single_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
  // R2: capture only while enable is low at the port
  assert_capture_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !scanEn);
endmodule

// File: rtl/scanrv_datapath.sv
module scanrv_datapath
  import scanrv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL  = '0,
  parameter logic [WIDTH-1:0] INVERT_MAP = '0,
  parameter int CNT_W = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  rvStrobes_t       strobes,
  input  logic [WIDTH-1:0] refBits,
  input  logic [WIDTH-1:0] implBits,
  output logic [WIDTH-1:0] mismatchVec,
  output logic [CNT_W-1:0] errCount,
  output logic             anyError
);
  localparam int PC_W  = $clog2(WIDTH + 1);
  localparam int SUM_W = ((CNT_W > PC_W) ? CNT_W : PC_W) + 1;
  localparam logic [SUM_W-1:0] SAT_WIDE = SUM_W'({CNT_W{1'b1}});

  logic [WIDTH-1:0] bitMiss;
  logic [PC_W-1:0]  missCount;
  logic [SUM_W-1:0] sumWide;
  logic [CNT_W-1:0] countNext;

  // each bit: views should differ exactly when reset value and polarity differ
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic expectDiffer = RESET_VAL[i] ^ INVERT_MAP[i];
    assign bitMiss[i] = (refBits[i] ^ implBits[i]) ^ expectDiffer;
  end

  function automatic logic [PC_W-1:0] countOnes(input logic [WIDTH-1:0] v);
    logic [PC_W-1:0] c;
    c = '0;
    for (int k = 0; k < WIDTH; k++) c = c + PC_W'(v[k]);
    return c;
  endfunction

  always_comb begin
    missCount = countOnes(bitMiss);
    sumWide   = SUM_W'(errCount) + SUM_W'(missCount);
    countNext = (sumWide > SAT_WIDE) ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mismatchVec <= '0;
      errCount    <= '0;
      anyError    <= 1'b0;
    end else begin
      if (strobes.capture) mismatchVec <= bitMiss;
      if (strobes.clear) begin
        errCount <= '0;
        anyError <= 1'b0;
      end else if (strobes.capture) begin
        errCount <= countNext;
        if (|bitMiss) anyError <= 1'b1;
      end
    end
  end

  // R12: result vector only moves on a capture
  assert_hold_vec_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(mismatchVec));
  // R8: counter never goes down without a clear
  assert_no_decrease_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |=> errCount >= $past(errCount));
  // R9: saturated counter stays saturated
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == {CNT_W{1'b1}} && !strobes.clear) |=> errCount == {CNT_W{1'b1}});
  // R11: sticky flag survives until clear
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (anyError && !strobes.clear) |=> anyError);
  // R10: clear empties counter and flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (errCount == '0 && !anyError));
endmodule

// File: rtl/scanRvChecker.sv
module scanRvChecker
  import scanrv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL  = 8'b0101_0011,
  parameter logic [WIDTH-1:0] INVERT_MAP = 8'b0011_0110,
  parameter int CNT_W = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanEn,
  input  logic             clrCnt,
  input  logic [WIDTH-1:0] refBits,
  input  logic [WIDTH-1:0] implBits,
  output logic [WIDTH-1:0] mismatchVec,
  output logic [CNT_W-1:0] errCount,
  output logic             anyError
);
  rvStrobes_t strobes;

  scanrv_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .scanEn  (scanEn),
    .clrCnt  (clrCnt),
    .strobes (strobes)
  );

  scanrv_datapath #(
    .WIDTH      (WIDTH),
    .RESET_VAL  (RESET_VAL),
    .INVERT_MAP (INVERT_MAP),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .refBits     (refBits),
    .implBits    (implBits),
    .mismatchVec (mismatchVec),
    .errCount    (errCount),
    .anyError    (anyError)
  );
endmodule

// File: tb/scanRvChecker_test.sv
module scanRvChecker_test;
  localparam logic [7:0] RV  = 8'b0101_0011;
  localparam logic [7:0] INV = 8'b0011_0110;
  // bit classes: R3 rv0/direct, R4 rv0/inverted, R5 rv1/direct, R6 rv1/inverted
  localparam logic [7:0] M_R3 = ~RV & ~INV;
  localparam logic [7:0] M_R4 = ~RV &  INV;
  localparam logic [7:0] M_R5 =  RV & ~INV;
  localparam logic [7:0] M_R6 =  RV &  INV;
  localparam int NV = 5;
  localparam logic [7:0] REF_TAB  [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h12};
  localparam logic [7:0] IMPL_TAB [NV] = '{8'h65, 8'hFF, 8'h5A, 8'h58, 8'h12};

  logic clk = 0, rstN = 0, scanEn = 0, clrCnt = 0;
  logic [7:0] refBits = '0, implBits = '0;
  logic [7:0] mismatchVec;
  logic [3:0] errCount;
  logic anyError;
  int total = 0, bad = 0;
  int modelCnt = 0;
  logic modelFlag = 0;

  always #4 clk = ~clk;

  scanRvChecker #(.WIDTH(8), .RESET_VAL(RV), .INVERT_MAP(INV), .CNT_W(4)) uut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .clrCnt(clrCnt),
    .refBits(refBits), .implBits(implBits),
    .mismatchVec(mismatchVec), .errCount(errCount), .anyError(anyError));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected mismatch from the rule: views differ iff reset value != polarity flag
  function automatic logic [7:0] expMiss(input logic [7:0] r, input logic [7:0] m);
    logic [7:0] e;
    for (int b = 0; b < 8; b++) begin
      logic shouldDiffer;
      shouldDiffer = (RV[b] != INV[b]);
      e[b] = ((r[b] != m[b]) != shouldDiffer);
    end
    return e;
  endfunction

  function automatic int ones(input logic [7:0] v);
    int c = 0;
    for (int b = 0; b < 8; b++) c += v[b];
    return c;
  endfunction

  task automatic modelCapture(input logic [7:0] e);
    modelCnt = modelCnt + ones(e);
    if (modelCnt > 15) modelCnt = 15;
    if (e != 0) modelFlag = 1;
  endtask

  task automatic capture(input logic [7:0] r, input logic [7:0] m, input logic withClr);
    @(negedge clk) scanEn = 1;
    @(negedge clk) begin scanEn = 0; refBits = r; implBits = m; clrCnt = withClr; end
    @(negedge clk) clrCnt = 0;
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] e, held;
    repeat (3) @(negedge clk);
    check("R1 mismatchVec", mismatchVec, 0);
    check("R1 errCount", errCount, 0);
    check("R1 anyError", anyError, 0);
    rstN = 1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      e = expMiss(REF_TAB[i], IMPL_TAB[i]);
      capture(REF_TAB[i], IMPL_TAB[i], 1'b0);
      modelCapture(e);
      check("R3 rv0 direct",   mismatchVec & M_R3, e & M_R3);
      check("R4 rv0 inverted", mismatchVec & M_R4, e & M_R4);
      check("R5 rv1 direct",   mismatchVec & M_R5, e & M_R5);
      check("R6 rv1 inverted", mismatchVec & M_R6, e & M_R6);
      check("R7 full vector",  mismatchVec, e);
      check("R8 count", errCount, modelCnt);
      check("R11 flag", anyError, modelFlag);
    end

    // R9 saturation: 13 + 4 -> 15, then stays
    capture(8'hFF, 8'hFF, 1'b0); modelCapture(expMiss(8'hFF, 8'hFF));
    check("R9 saturate", errCount, 15);
    capture(8'h00, 8'h00, 1'b0); modelCapture(expMiss(8'h00, 8'h00));
    check("R9 hold at max", errCount, 15);
    held = mismatchVec;

    // R2 / R12: data changes while enable stays high, then stays low
    @(negedge clk) scanEn = 1;
    repeat (3) @(negedge clk) begin refBits = refBits + 8'h11; implBits = ~implBits; end
    check("R2 no capture while high", mismatchVec, held);
    @(negedge clk) begin scanEn = 0; refBits = 8'h00; implBits = 8'h65; end
    @(negedge clk);
    check("R2 capture on fall", mismatchVec, 8'h00);
    check("R9 count after all-pass", errCount, 15);
    repeat (3) @(negedge clk) begin refBits = refBits + 8'h07; implBits = 8'hFF; end
    check("R12 hold while low", mismatchVec, 8'h00);
    check("R2 count unchanged while low", errCount, 15);

    // R10 clear alone
    @(negedge clk) clrCnt = 1;
    @(negedge clk) clrCnt = 0;
    check("R10 clear count", errCount, 0);
    check("R10 clear flag", anyError, 0);
    check("R10 vec untouched", mismatchVec, 8'h00);
    modelCnt = 0; modelFlag = 0;

    // R10 clear and capture on same edge: clear wins on count, vector follows capture
    capture(8'hFF, 8'hFF, 1'b1);
    check("R10 clear priority count", errCount, 0);
    check("R10 clear priority flag", anyError, 0);
    check("R10 vec on clear+capture", mismatchVec, expMiss(8'hFF, 8'hFF));

    // R11 sticky through an all-pass capture
    capture(8'hA5, 8'hA5, 1'b0);
    check("R11 flag set", anyError, 1);
    check("R8 count 4", errCount, 4);
    capture(8'h3C, 8'h3C ^ 8'h65, 1'b0);
    check("R11 flag sticky", anyError, 1);
    check("R12 vec zero after pass", mismatchVec, 8'h00);
    check("R8 count unchanged on pass", errCount, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule